// File: doc/BRIEF.md
# ECC Error Status Arbiter

This block gathers ECC error events from two read paths that run at the same time, an instruction-fetch path and a data-read path, and from a signature-check engine that scans memory as a built-in command. Each read path reports, per cycle, a pulse for a corrected single-bit error, a pulse for a detected double-bit error, and the address of the access. The block keeps one sticky status flag per event kind and source, a register holding the address of the last interrupt-worthy read error, and a single interrupt line.

When both read paths report an error in the same cycle, one rule picks the only event that is recorded. Severity decides first, so a double-bit detection beats a single-bit correction. If severity is equal, the instruction path wins. The losing event is dropped. Errors found by the signature engine are gathered while the check runs. They reach the status flags only when the completion strobe arrives, and they never touch the address register. Software clears flags by writing ones to them, and it enables interrupts for corrected and for detected events separately.

Top module: `ecc_err_status`

## Requirements
- R1: When both read paths report in one cycle and only one of them reports a double-bit detection, only that path's detected flag sets. The other path's flags stay unchanged. Status bit map: bit 0 instruction corrected, bit 1 instruction detected, bit 2 data corrected, bit 3 data detected, bit 4 signature corrected, bit 5 signature detected.
- R2: When both read paths report events of the same severity in one cycle, only the instruction path's flag for that severity sets.
- R3: `irq` is high exactly when a set corrected flag (bit 0, 2 or 4) has `ien_corr` high, or a set detected flag (bit 1, 3 or 5) has `ien_det` high. The enables do not stop flags from setting.
- R4: `err_addr` loads the winning event's address on the edge after that event, but only if the enable for that event's kind is high. Otherwise it holds its value.
- R5: Signature-check error pulses are accumulated. They set bit 4 or bit 5 only on the edge that samples `sig_done`, and pulses that arrive in the same cycle as `sig_done` are included.
- R6: Signature-check errors never change `err_addr`.
- R7: Flags are sticky. A cycle with `clr_we` high clears each flag whose `clr_mask` bit is 1. A flag that is set in the same cycle it is cleared stays set.
- R8: After reset, `status`, `err_addr` and `irq` are all zero.
- R9: A read path that reports corrected and detected together in one cycle is recorded as a detected event only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| if_corr | input | 1 | Instruction path single-bit corrected pulse |
| if_det | input | 1 | Instruction path double-bit detected pulse |
| if_addr | input | AW | Instruction path access address |
| dr_corr | input | 1 | Data path single-bit corrected pulse |
| dr_det | input | 1 | Data path double-bit detected pulse |
| dr_addr | input | AW | Data path access address |
| sig_corr | input | 1 | Signature engine corrected-word pulse |
| sig_det | input | 1 | Signature engine detected-word pulse |
| sig_done | input | 1 | Signature check completion strobe |
| ien_corr | input | 1 | Interrupt enable for corrected events |
| ien_det | input | 1 | Interrupt enable for detected events |
| clr_we | input | 1 | Write-one-to-clear strobe |
| clr_mask | input | 6 | Flags to clear when `clr_we` is high |
| status | output | 6 | Sticky status flags |
| err_addr | output | AW | Address of the last qualifying read error |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that every input is stable around the rising edge and that the signature engine and the read paths are independent sources. In particular, they assume a flag is not cleared in the cycle being checked. The sticky and priority properties are therefore guarded by that flag's `clr_mask` bit or by its current value. The stimulus drives every input on the falling edge, holds each event for exactly one cycle, and only clears flags in cycles that are dedicated to clearing, except in the one test that deliberately overlaps a clear with a set.

// File: rtl/ecc_err_status.sv
module ecc_err_status #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          if_corr,
  input  logic          if_det,
  input  logic [AW-1:0] if_addr,
  input  logic          dr_corr,
  input  logic          dr_det,
  input  logic [AW-1:0] dr_addr,
  input  logic          sig_corr,
  input  logic          sig_det,
  input  logic          sig_done,
  input  logic          ien_corr,
  input  logic          ien_det,
  input  logic          clr_we,
  input  logic [5:0]    clr_mask,
  output logic [5:0]    status,
  output logic [AW-1:0] err_addr,
  output logic          irq
);

  logic       if_ev, dr_ev, any_det;
  logic       win_if, win_det;
  logic [5:0] set_v;
  logic       pend_c, pend_d;

  assign if_ev   = if_corr | if_det;
  assign dr_ev   = dr_corr | dr_det;
  assign any_det = if_det | dr_det;
  // severity first, then instruction path
  assign win_if  = if_ev & (if_det | ~dr_det);
  assign win_det = win_if ? if_det : dr_det;

  assign set_v[0] = win_if & ~if_det;
  assign set_v[1] = win_if & if_det;
  assign set_v[2] = ~win_if & dr_ev & ~dr_det;
  assign set_v[3] = ~win_if & dr_det;
  assign set_v[4] = sig_done & (pend_c | sig_corr);
  assign set_v[5] = sig_done & (pend_d | sig_det);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      pend_c <= 1'b0;
      pend_d <= 1'b0;
    end else begin
      status <= (status & ~(clr_we ? clr_mask : 6'b0)) | set_v;
      pend_c <= ~sig_done & (pend_c | sig_corr);
      pend_d <= ~sig_done & (pend_d | sig_det);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      err_addr <= '0;
    else if ((if_ev | dr_ev) && (win_det ? ien_det : ien_corr))
      err_addr <= win_if ? if_addr : dr_addr;
  end

  assign irq = (ien_corr & (status[0] | status[2] | status[4])) |
               (ien_det  & (status[1] | status[3] | status[5]));

  AST_DET_BEATS_CORR: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_det && if_corr && !if_det && !status[0]) |=> !status[0]); // R1
  AST_IF_WINS_TIE: assert property (@(posedge clk) disable iff (!rst_n)
    (if_det && dr_det && !status[3]) |=> !status[3]); // R2
  AST_IRQ_FROM_DET: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && ien_det) |-> irq); // R3
  AST_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (if_det && ien_det) |=> (err_addr == $past(if_addr))); // R4
  AST_ADDR_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!if_corr && !if_det && !dr_corr && !dr_det) |=> $stable(err_addr)); // R6
  AST_SIG_WAITS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sig_done && !status[4]) |=> !status[4]); // R5
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && !(clr_we && clr_mask[1])) |=> status[1]); // R7
  AST_BOTH_IS_DET: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_corr && dr_det && !if_ev && !status[2]) |=> !status[2]); // R9

endmodule

// File: tb/ecc_err_status_test.sv
module ecc_err_status_test;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          if_corr = 0, if_det = 0, dr_corr = 0, dr_det = 0;
  logic [AW-1:0] if_addr = '0, dr_addr = '0;
  logic          sig_corr = 0, sig_det = 0, sig_done = 0;
  logic          ien_corr = 0, ien_det = 0, clr_we = 0;
  logic [5:0]    clr_mask = '0;
  logic [5:0]    status;
  logic [AW-1:0] err_addr;
  logic          irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ecc_err_status #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .if_corr(if_corr), .if_det(if_det), .if_addr(if_addr),
    .dr_corr(dr_corr), .dr_det(dr_det), .dr_addr(dr_addr),
    .sig_corr(sig_corr), .sig_det(sig_det), .sig_done(sig_done),
    .ien_corr(ien_corr), .ien_det(ien_det),
    .clr_we(clr_we), .clr_mask(clr_mask),
    .status(status), .err_addr(err_addr), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    {if_corr, if_det, dr_corr, dr_det, sig_corr, sig_det, sig_done, clr_we} = '0;
  endtask

  task automatic ev(input logic ic, input logic id, input logic [AW-1:0] ia,
                    input logic dc, input logic dd, input logic [AW-1:0] da);
    @(negedge clk);
    if_corr = ic; if_det = id; if_addr = ia;
    dr_corr = dc; dr_det = dd; dr_addr = da;
    idle();
  endtask

  task automatic clear_all();
    @(negedge clk);
    clr_we = 1; clr_mask = 6'h3f;
    idle();
  endtask

  task automatic t_reset();
    chk("R8 status", 32'(status), 0);
    chk("R8 addr", 32'(err_addr), 0);
    chk("R8 irq", 32'(irq), 0);
  endtask

  task automatic t_severity();
    ien_corr = 1; ien_det = 1;
    ev(1, 0, 24'h000A10, 0, 1, 24'h000B20);
    chk("R1 status", 32'(status), 32'h08);
    chk("R1 addr", 32'(err_addr), 32'h000B20);
    chk("R3 irq", 32'(irq), 1);
    clear_all();
    ev(0, 1, 24'h000C30, 1, 0, 24'h000D40);
    chk("R1 if det beats dr corr", 32'(status), 32'h02);
  endtask

  task automatic t_tie();
    clear_all();
    ev(0, 1, 24'h001111, 0, 1, 24'h002222);
    chk("R2 det tie", 32'(status), 32'h02);
    chk("R2 det tie addr", 32'(err_addr), 32'h001111);
    clear_all();
    ev(1, 0, 24'h003333, 1, 0, 24'h004444);
    chk("R2 corr tie", 32'(status), 32'h01);
    chk("R2 corr tie addr", 32'(err_addr), 32'h003333);
  endtask

  task automatic t_both();
    clear_all();
    ev(0, 0, 24'h0, 1, 1, 24'h005555);
    chk("R9 both bits", 32'(status), 32'h08);
  endtask

  task automatic t_irq();
    ien_corr = 0; ien_det = 0;
    clear_all();
    ev(1, 0, 24'h006666, 0, 0, 24'h0);
    chk("R3 flag without enable", 32'(status), 32'h01);
    chk("R3 irq off", 32'(irq), 0);
    ien_det = 1; #1;
    chk("R3 det enable only", 32'(irq), 0);
    ien_corr = 1; #1;
    chk("R3 corr enable", 32'(irq), 1);
  endtask

  task automatic t_addr();
    ien_corr = 1; ien_det = 1;
    ev(0, 0, 24'h0, 1, 0, 24'h00ABCD);
    chk("R4 corr capture", 32'(err_addr), 32'h00ABCD);
    ien_corr = 0;
    ev(1, 0, 24'h00F00D, 0, 0, 24'h0);
    chk("R4 disabled hold", 32'(err_addr), 32'h00ABCD);
    ev(0, 0, 24'h0, 0, 1, 24'h00BEEF);
    chk("R4 det capture", 32'(err_addr), 32'h00BEEF);
    idle(); idle();
    chk("R4 idle hold", 32'(err_addr), 32'h00BEEF);
  endtask

  task automatic t_sig();
    ien_corr = 1; ien_det = 1;
    clear_all();
    @(negedge clk); sig_corr = 1; idle();
    chk("R5 no early corr", 32'(status), 0);
    @(negedge clk); sig_det = 1; idle();
    idle();
    chk("R5 no early det", 32'(status), 0);
    @(negedge clk); sig_done = 1; idle();
    chk("R5 done", 32'(status), 32'h30);
    chk("R6 addr untouched", 32'(err_addr), 32'h00BEEF);
    chk("R3 sig irq", 32'(irq), 1);
    clear_all();
    @(negedge clk); sig_det = 1; sig_done = 1; idle();
    chk("R5 same-cycle pulse", 32'(status), 32'h20);
    @(negedge clk); sig_done = 1; idle();
    chk("R5 pending cleared", 32'(status), 32'h20);
  endtask

  task automatic t_w1c();
    ev(1, 0, 24'h000001, 0, 0, 24'h0);
    chk("R7 pre", 32'(status), 32'h21);
    @(negedge clk); clr_we = 1; clr_mask = 6'h20; idle();
    chk("R7 masked clear", 32'(status), 32'h01);
    idle(); idle();
    chk("R7 sticky", 32'(status), 32'h01);
    @(negedge clk); clr_we = 1; clr_mask = 6'h01; if_corr = 1; idle();
    chk("R7 set wins over clear", 32'(status), 32'h01);
    @(negedge clk); clr_mask = 6'h3f; if_corr = 0;
    idle();
    chk("R7 no clear without strobe", 32'(status), 32'h01);
  endtask

  initial begin
    #1;
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_severity();
    t_tie();
    t_both();
    t_irq();
    t_addr();
    t_sig();
    t_w1c();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #50000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule